// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank with Latched Readback

This block holds four down-counting timers behind a small memory-mapped register port (address, write enable, write data, read enable, registered read data). Timers 1 and 2 are short counters whose counts share one packed readback word. Timers 3 and 4 are long counters, and each has its own readback word. Each timer reloads from its own preload register when it reaches zero and raises a "caused interrupt" flag. One combined interrupt output reports every raised flag whose interrupt enable is set.

Software picks a read-latch mode. In per-field mode, every count read samples the live counter. In coherent mode, a read of the packed word for timers 1 and 2 also freezes copies of timers 3 and 4, so later reads of those timers match that instant. There are two ways to drop a flag. One is a write of any data to a dedicated write-only clear offset (timers 1 and 2 only). The other is writing 0 to the flag's bit in the control word.

Top module: `multi_timer_regs`

## Requirements
- R1: A read at offset 0x20 returns timer 2's count in bits 31:16 and timer 1's count in bits 15:0.
- R2: Offsets 0x08, 0x0C, 0x10 and 0x14 are the preloads of timers 1 to 4. They read back truncated to the timer width. A preload write also loads the counter. Offset 0x24 returns the full count of timer 3 and offset 0x28 the full count of timer 4.
- R3: A timer whose run bit (control word at 0x00, bit i-1 for timer i) is set decrements by one every clock. A timer whose run bit is clear holds its count.
- R4: A running timer at zero reloads from its preload on the next clock and sets its caused flag (control word bit 7+i for timer i).
- R5: With bit 0 of the mode word at 0x04 clear, every count read returns the live count at the read-enable clock edge, one cycle later on rd_data_o.
- R6: With mode bit 0 set, a read of 0x20 also captures timers 3 and 4. Reads of 0x24 and 0x28 then return those captured values until the next read of 0x20.
- R7: A write of any data to 0x30 clears timer 1's flag, and a write to 0x34 clears timer 2's flag. The other flags are left as they are.
- R8: Writing 0 to a caused-flag bit of the control word clears that flag. Writing 1 has no effect.
- R9: When a flag is set and cleared in the same cycle, it ends up set.
- R10: irq_o is high exactly when some timer has both its flag and its interrupt enable set (control word bit 3+i for timer i).
- R11: Reads of 0x30, 0x34 and of unmapped offsets return 0 and change no state.
- R12: After reset, all registers, counts, flags, rd_data_o and irq_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte offset of the access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DW | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DW | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Combined timer interrupt |

## Verification
The bench builds the block with SHORT_W=16, LONG_W=32, DW=32 and AW=6. With these widths the packed word for timers 1 and 2 fills the data bus exactly, and an over-wide write to a short preload shows the truncation. Preloads of 0 and 3 reach the reload within a few cycles, which exercises flag setting, both clear paths and the set-versus-clear race. Large preloads keep timers 1 and 3 from wrapping, so exact decrement distances and the fixed difference between snapshot values can be predicted.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int NUM_TMR   = 4;
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_MODE  = 'h04;
  localparam int OFF_PRE0  = 'h08;
  localparam int OFF_CNT12 = 'h20;
  localparam int OFF_CNT3  = 'h24;
  localparam int OFF_CNT4  = 'h28;
  localparam int OFF_CLR1  = 'h30;
  localparam int OFF_CLR2  = 'h34;
endpackage

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] pre_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (ld_i) begin
      cnt_q <= ld_val_i;
      pre_q <= ld_val_i;
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? pre_q : cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign pre_o  = pre_q;
  assign wrap_o = run_i && (cnt_q == '0);

  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !ld_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !ld_i |=> $stable(cnt_q)); // R3
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !ld_i && cnt_q == '0 |=> cnt_q == pre_q); // R4
endmodule

// File: rtl/mtmr_flag.sv
module mtmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R9
  AST_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_o); // R7
  AST_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i |=> $stable(flag_o)); // R8
endmodule

// File: rtl/multi_timer_regs.sv
module multi_timer_regs
  import mtmr_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 32,
  parameter int DW      = 32,
  parameter int AW      = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  localparam int NT       = NUM_TMR;
  localparam int FLAG_LSB = 2 * NT;

  logic [NT-1:0] run_q, ie_q, flags, wrap, clr, ld;
  logic          mode_q;
  logic [DW-1:0] cnt_all [NT];
  logic [DW-1:0] pre_all [NT];
  logic [DW-1:0] snap3_q, snap4_q, rd_mux;

  logic wr_ctrl, wr_mode, wr_clr1, wr_clr2, rd_c12, rd_c3, rd_c4;
  assign wr_ctrl = wr_en_i && addr_i == AW'(OFF_CTRL);
  assign wr_mode = wr_en_i && addr_i == AW'(OFF_MODE);
  assign wr_clr1 = wr_en_i && addr_i == AW'(OFF_CLR1);
  assign wr_clr2 = wr_en_i && addr_i == AW'(OFF_CLR2);
  assign rd_c12  = rd_en_i && addr_i == AW'(OFF_CNT12);
  assign rd_c3   = rd_en_i && addr_i == AW'(OFF_CNT3);
  assign rd_c4   = rd_en_i && addr_i == AW'(OFF_CNT4);

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      ld[i]  = wr_en_i && addr_i == AW'(OFF_PRE0 + 4 * i);
      clr[i] = wr_ctrl && !wr_data_i[FLAG_LSB+i];
    end
    clr[0] = clr[0] | wr_clr1;
    clr[1] = clr[1] | wr_clr2;
  end

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam int TW = (i < 2) ? SHORT_W : LONG_W;
    logic [TW-1:0] cnt, pre;
    mtmr_counter #(.W(TW)) u_cnt (
      .clk_i, .rst_ni,
      .run_i   (run_q[i]),
      .ld_i    (ld[i]),
      .ld_val_i(wr_data_i[TW-1:0]),
      .cnt_o   (cnt),
      .pre_o   (pre),
      .wrap_o  (wrap[i])
    );
    mtmr_flag u_flag (
      .clk_i, .rst_ni,
      .set_i (wrap[i]),
      .clr_i (clr[i]),
      .flag_o(flags[i])
    );
    assign cnt_all[i] = DW'(cnt);
    assign pre_all[i] = DW'(pre);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      ie_q   <= '0;
      mode_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wr_data_i[NT-1:0];
        ie_q  <= wr_data_i[2*NT-1:NT];
      end
      if (wr_mode) mode_q <= wr_data_i[0];
    end
  end

  // Coherent mode: the packed read freezes the long timers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap3_q <= '0;
      snap4_q <= '0;
    end else if (rd_c12 && mode_q) begin
      snap3_q <= cnt_all[2];
      snap4_q <= cnt_all[3];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NT; i++)
      if (addr_i == AW'(OFF_PRE0 + 4 * i)) rd_mux = pre_all[i];
    if (addr_i == AW'(OFF_CTRL))  rd_mux = DW'({flags, ie_q, run_q});
    if (addr_i == AW'(OFF_MODE))  rd_mux = DW'(mode_q);
    if (addr_i == AW'(OFF_CNT12)) rd_mux = (cnt_all[1] << SHORT_W) | cnt_all[0];
    if (addr_i == AW'(OFF_CNT3))  rd_mux = mode_q ? snap3_q : cnt_all[2];
    if (addr_i == AW'(OFF_CNT4))  rd_mux = mode_q ? snap4_q : cnt_all[3];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
    else              rd_data_o <= '0;
  end

  assign irq_o = |(flags & ie_q);

  AST_WO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (addr_i == AW'(OFF_CLR1) || addr_i == AW'(OFF_CLR2)) |=> rd_data_o == '0); // R11
  AST_SNAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q && !rd_c12 |=> $stable(snap3_q) && $stable(snap4_q)); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags != '0)); // R10
endmodule

// File: tb/sim_multi_timer_regs.sv
module sim_multi_timer_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int checks = 0, errors = 0;
  logic [31:0] a, b, c, w, w2;

  always #2 clk = ~clk; // 250 MHz

  multi_timer_regs #(.SHORT_W(16), .LONG_W(32), .DW(32), .AW(6)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data), .irq_o(irq)
  );

  // {write, addr, data, expected}
  localparam int NV = 17;
  localparam logic [70:0] VEC [NV] = '{
    {1'b1, 6'h08, 32'h0000_1234, 32'h0},
    {1'b1, 6'h0C, 32'hFFFF_ABCD, 32'h0},
    {1'b1, 6'h10, 32'hDEAD_BEEF, 32'h0},
    {1'b1, 6'h14, 32'h0102_0304, 32'h0},
    {1'b0, 6'h20, 32'h0, 32'hABCD_1234},
    {1'b0, 6'h24, 32'h0, 32'hDEAD_BEEF},
    {1'b0, 6'h28, 32'h0, 32'h0102_0304},
    {1'b0, 6'h0C, 32'h0, 32'h0000_ABCD},
    {1'b0, 6'h14, 32'h0, 32'h0102_0304},
    {1'b1, 6'h04, 32'h1, 32'h0},
    {1'b0, 6'h04, 32'h0, 32'h1},
    {1'b1, 6'h04, 32'h0, 32'h0},
    {1'b0, 6'h04, 32'h0, 32'h0},
    {1'b0, 6'h30, 32'h0, 32'h0},
    {1'b0, 6'h34, 32'h0, 32'h0},
    {1'b0, 6'h3C, 32'h0, 32'h0},
    {1'b0, 6'h00, 32'h0, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] ad, input logic [31:0] d);
    @(negedge clk);
    addr = ad; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] ad, output logic [31:0] d);
    @(negedge clk);
    addr = ad; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %h expected %h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 rd_data at reset", rd_data, 32'h0);
    chk("R12 irq at reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    rd(6'h00, a); chk("R12 control after reset", a, 32'h0);
    rd(6'h20, a); chk("R12 counts after reset", a, 32'h0);

    // R1 R2 R11 table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) wr(VEC[i][69:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][69:64], a);
        chk($sformatf("R1/R2/R11 table[%0d]", i), a, VEC[i][31:0]);
      end
    end

    // R3 R5: exact decrement distances in per-field mode
    wr(6'h10, 32'd1000);
    wr(6'h00, 32'hF04);
    rd(6'h24, a); rd(6'h24, b);
    chk("R3/R5 back-to-back read distance", a - b, 32'd2);
    repeat (5) @(negedge clk);
    rd(6'h24, c);
    chk("R3/R5 spaced read distance", b - c, 32'd7);
    wr(6'h00, 32'hF00);
    rd(6'h24, a); repeat (3) @(negedge clk); rd(6'h24, b);
    chk("R3 stopped timer holds", b, a);

    // R6: coherent snapshot
    wr(6'h08, 32'h0000_F000);
    wr(6'h10, 32'h0010_0000);
    wr(6'h04, 32'h1);
    wr(6'h00, 32'hF05);
    rd(6'h20, w); rd(6'h24, a);
    chk("R6 snapshot coherent with timer 1", a - {16'h0, w[15:0]}, 32'h000F_1000);
    repeat (4) @(negedge clk);
    rd(6'h24, b);
    chk("R6 snapshot frozen", b, a);
    rd(6'h20, w2); rd(6'h24, c);
    chk("R6 snapshot refreshed", a - c, {16'h0, w[15:0] - w2[15:0]});
    wr(6'h04, 32'h0);
    rd(6'h24, a); rd(6'h24, b);
    chk("R5 live reads after mode 0", a - b, 32'd2);
    wr(6'h00, 32'h000);

    // R4 R10 R11 R7: flags and dedicated clears
    wr(6'h08, 32'd3); wr(6'h0C, 32'd3);
    wr(6'h00, 32'hF33);
    repeat (10) @(negedge clk);
    wr(6'h00, 32'hF30);
    rd(6'h00, a); chk("R4 flags set on reload", a, 32'h330);
    chk("R10 irq with enabled flag", {31'b0, irq}, 32'h1);
    rd(6'h30, a); chk("R11 read of clear offset", a, 32'h0);
    rd(6'h00, a); chk("R11 read left flags", a, 32'h330);
    wr(6'h30, 32'h0);
    rd(6'h00, a); chk("R7 clear offset timer 1", a, 32'h230);
    chk("R10 irq from timer 2 alone", {31'b0, irq}, 32'h1);
    wr(6'h34, 32'hFFFF_FFFF);
    rd(6'h00, a); chk("R7 clear offset timer 2", a, 32'h030);
    chk("R10 irq low with no flags", {31'b0, irq}, 32'h0);

    // R8 R10: write-zero clear, write-one ignored, masking
    wr(6'h00, 32'hF33);
    repeat (10) @(negedge clk);
    wr(6'h00, 32'hF30);
    wr(6'h00, 32'hD30);
    rd(6'h00, a); chk("R8 write zero clears timer 2", a, 32'h130);
    wr(6'h00, 32'hF30);
    rd(6'h00, a); chk("R8 write one has no effect", a, 32'h130);
    wr(6'h00, 32'hF00);
    chk("R10 masked flag", {31'b0, irq}, 32'h0);
    wr(6'h00, 32'hF20);
    chk("R10 enable without flag", {31'b0, irq}, 32'h0);
    wr(6'h00, 32'hF10);
    chk("R10 enable with flag", {31'b0, irq}, 32'h1);

    // R9: set every cycle against both clears
    wr(6'h00, 32'h000);
    wr(6'h08, 32'd0);
    wr(6'h00, 32'hF01);
    wr(6'h30, 32'h0);
    rd(6'h00, a); chk("R9 set beats clear offset", a, 32'h101);
    wr(6'h00, 32'h001);
    rd(6'h00, a); chk("R9 set beats write-zero", a, 32'h101);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule